// File: doc/BRIEF.md
# Buffered Five-Channel Down-Count PWM Timer

This block holds five down-counting timer channels behind a small word-addressed register bus. Two 8-bit prescalers each serve a group of channels, and every channel then divides its group's prescaled tick by a power of two that it selects itself. Channels 0 to 3 drive PWM pins. Channel 4 is a plain interval timer with no compare and no pin.

Each channel keeps a count buffer and, for channels 0 to 3, a compare buffer. Writing a buffer does not touch the running counter. The values reach the live counter and compare registers only in two ways: while software holds the channel's update bit set, or at the moment the counter expires with auto-reload enabled. On each such reload the channel raises a one-cycle expiry flag. Duty is set by writing compare = count − active_ticks.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset every register reads 0, all PWM pins are low and no expiry flag is raised.
- R2: Register map by word address. Word 0 is the prescaler word. Word 1 is the divider word. Word 2 is the control word. The count buffer of channel n is at 3+3n. The compare buffer of channel n (n<4) is at 4+3n. Words 0, 1 and 2 read back the last written 32-bit value, and buffers read back their written low bits. Word 16 (the missing compare of channel 4) ignores writes and reads 0, and every unmapped word reads 0. In the control word, channel n<4 uses bit 4n for start, 4n+1 for update, 4n+2 for invert and 4n+3 for auto-reload. Channel 4 uses bit 16 for start, bit 17 for update and bit 18 for auto-reload.
- R3: Prescaler word bits 7:0 serve channels 0 and 1, and bits 15:8 serve channels 2, 3 and 4. A field value p divides the clock by p+1.
- R4: Divider word bits 4n+3:4n hold channel n's select s, and the channel tick is the prescaled tick divided by 2^s.
- R5: With auto-reload set, a running channel with live count N raises its expiry flag once every (p+1)·2^s·(N+1) clock cycles.
- R6: With invert clear, the pin is high for exactly (N−C)·(p+1)·2^s cycles of each period, where C is the live compare. The pin is high while the counter value exceeds C.
- R7: The invert bit flips the pin. A stopped channel holds its pin at the invert bit's value.
- R8: While a channel's update bit is set, its live count and compare follow the buffers every cycle, counting is suspended and no expiry is raised. Clearing the bit resumes counting from the loaded value.
- R9: A count buffer written while a channel runs changes nothing until the next expiry, and the periods after that reload use the new value.
- R10: With auto-reload clear, a channel counts down to zero and stays there, raising no expiry flag.
- R11: Clearing start halts the channel. Setting it again resumes counting with the same buffered period.
- R12: Channel 4 counts with its own control bits and raises expiry flags at the R5 rate using prescaler bits 15:8, and it has no PWM pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_pin | output | 4 | PWM pins of channels 0 to 3 |
| expire | output | 5 | One-cycle expiry flag per channel |

## Verification
Two functions can claim the live counter in the same cycle: the manual update copy and the expiry reload. The bench provokes the collision by holding a channel's update bit set while that channel runs with auto-reload. It then confirms that no expiry flag appears and that the pin stays frozen at the level the loaded values give. Once the bit is cleared, the bench checks that the first measured period matches the loaded count. The checker adds a second judgement: any expiry must follow a cycle where the channel was started, set to reload and not being updated.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int NCH       = 5;
  localparam int NPWM      = 4;
  localparam int GRP_A_NCH = 2;
  localparam int SEL_W     = 4;
  localparam int DIVC_W    = (1 << SEL_W) - 1;
  localparam int PSC_ADDR  = 0;
  localparam int DIV_ADDR  = 1;
  localparam int CTL_ADDR  = 2;
  localparam int BUF_BASE  = 3;
  localparam int BUF_STEP  = 3;

  // mask of the low s divider bits; a tick fires when they are all ones
  function automatic logic [DIVC_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [DIVC_W:0] one;
    one = 1;
    return DIVC_W'((one << sel) - one);
  endfunction

  // base bit of a channel's field in the control word
  function automatic int ctl_pos(input int n);
    return (n < NPWM) ? 4 * n : 16;
  endfunction

  function automatic int reload_pos(input int n);
    return (n < NPWM) ? ctl_pos(n) + 3 : ctl_pos(n) + 2;
  endfunction

  function automatic int cnt_addr(input int n);
    return BUF_BASE + BUF_STEP * n;
  endfunction

  function automatic int cmp_addr(input int n);
    return BUF_BASE + BUF_STEP * n + 1;
  endfunction
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [PSC_W-1:0]              psc_a,
  output logic [PSC_W-1:0]              psc_b,
  output logic [NCH-1:0][SEL_W-1:0]     sel,
  output logic [NCH-1:0]                start,
  output logic [NCH-1:0]                update,
  output logic [NCH-1:0]                invert,
  output logic [NCH-1:0]                reload,
  output logic [NCH-1:0][CNT_W-1:0]     cbuf,
  output logic [NCH-1:0][CNT_W-1:0]     mbuf
);
  logic [DATA_W-1:0]          psc_q, div_q, ctl_q;
  logic [NCH-1:0][CNT_W-1:0]  cbuf_q, mbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      div_q  <= '0;
      ctl_q  <= '0;
      cbuf_q <= '0;
      mbuf_q <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(PSC_ADDR)) psc_q <= wdata;
      if (addr == ADDR_W'(DIV_ADDR)) div_q <= wdata;
      if (addr == ADDR_W'(CTL_ADDR)) ctl_q <= wdata;
      for (int n = 0; n < NCH; n++) begin
        if (addr == ADDR_W'(cnt_addr(n))) cbuf_q[n] <= wdata[CNT_W-1:0];
        if (n < NPWM && addr == ADDR_W'(cmp_addr(n))) mbuf_q[n] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(PSC_ADDR)) rdata = psc_q;
    if (addr == ADDR_W'(DIV_ADDR)) rdata = div_q;
    if (addr == ADDR_W'(CTL_ADDR)) rdata = ctl_q;
    for (int n = 0; n < NCH; n++) begin
      if (addr == ADDR_W'(cnt_addr(n))) rdata = DATA_W'(cbuf_q[n]);
      if (n < NPWM && addr == ADDR_W'(cmp_addr(n))) rdata = DATA_W'(mbuf_q[n]);
    end
  end

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      sel[n]    = div_q[n*SEL_W +: SEL_W];
      start[n]  = ctl_q[ctl_pos(n)];
      update[n] = ctl_q[ctl_pos(n) + 1];
      invert[n] = (n < NPWM) ? ctl_q[ctl_pos(n) + 2] : 1'b0;
      reload[n] = ctl_q[reload_pos(n)];
    end
  end

  assign psc_a = psc_q[PSC_W-1:0];
  assign psc_b = psc_q[2*PSC_W-1:PSC_W];
  assign cbuf  = cbuf_q;
  assign mbuf  = mbuf_q;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] pc_q;

  assign tick = active && (pc_q >= psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pc_q <= '0;
    else if (!active)     pc_q <= '0;
    else if (tick)        pc_q <= '0;
    else                  pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit HAS_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psc_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             start,
  input  logic             update,
  input  logic             reload,
  input  logic             invert,
  input  logic [CNT_W-1:0] cbuf,
  input  logic [CNT_W-1:0] mbuf,
  output logic             ch_tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire,
  output logic             pin
);
  logic [DIVC_W-1:0] dcnt_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              active;

  assign ch_tick = start && psc_tick && ((dcnt_q & div_mask(sel)) == div_mask(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dcnt_q <= '0;
    else if (!start)   dcnt_q <= '0;
    else if (psc_tick) dcnt_q <= dcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (update) begin
        cnt_q <= cbuf;
        cmp_q <= mbuf;
      end else if (ch_tick) begin
        if (cnt_q == '0) begin
          if (reload) begin
            cnt_q  <= cbuf;
            cmp_q  <= mbuf;
            expire <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign active = start && (cnt_q > cmp_q);

  generate
    if (HAS_OUT) begin : g_pin
      assign pin = active ^ invert;
    end else begin : g_nopin
      assign pin = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
  import pwm_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NPWM-1:0]   pwm_pin,
  output logic [NCH-1:0]    expire
);
  logic [PSC_W-1:0]           psc_a, psc_b;
  logic [NCH-1:0][SEL_W-1:0]  ch_sel;
  logic [NCH-1:0]             ch_start, ch_update, ch_invert, ch_reload;
  logic [NCH-1:0][CNT_W-1:0]  cnt_buf, cmp_buf, live_cnt;
  logic [NCH-1:0]             ch_tick, pin_all;
  logic [1:0]                 grp_active, grp_tick;

  pwm_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .psc_a(psc_a), .psc_b(psc_b), .sel(ch_sel),
    .start(ch_start), .update(ch_update), .invert(ch_invert), .reload(ch_reload),
    .cbuf(cnt_buf), .mbuf(cmp_buf)
  );

  assign grp_active[0] = |ch_start[GRP_A_NCH-1:0];
  assign grp_active[1] = |ch_start[NCH-1:GRP_A_NCH];

  generate
    for (genvar g = 0; g < 2; g++) begin : g_psc
      pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .active(grp_active[g]),
        .psc((g == 0) ? psc_a : psc_b), .tick(grp_tick[g])
      );
    end
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      pwm_channel #(.CNT_W(CNT_W), .HAS_OUT(n < NPWM)) u_ch (
        .clk(clk), .rst_n(rst_n),
        .psc_tick(grp_tick[(n < GRP_A_NCH) ? 0 : 1]), .sel(ch_sel[n]),
        .start(ch_start[n]), .update(ch_update[n]), .reload(ch_reload[n]),
        .invert(ch_invert[n]), .cbuf(cnt_buf[n]), .mbuf(cmp_buf[n]),
        .ch_tick(ch_tick[n]), .cnt_q(live_cnt[n]), .expire(expire[n]), .pin(pin_all[n])
      );
    end
  endgenerate

  assign pwm_pin = pin_all[NPWM-1:0];
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            ch_start,
  input logic [NCH-1:0]            ch_update,
  input logic [NCH-1:0]            ch_reload,
  input logic [NCH-1:0]            ch_tick,
  input logic [NCH-1:0][CNT_W-1:0] live_cnt,
  input logic [NCH-1:0][CNT_W-1:0] cnt_buf,
  input logic [NCH-1:0]            expire,
  input logic [NCH-1:0]            pin_all
);
  generate
    for (genvar n = 0; n < NCH; n++) begin : g_c
      // R8
      update_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_update[n] |=> live_cnt[n] == $past(cnt_buf[n]));
      // R5
      expire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire[n] |-> $past(ch_start[n] && ch_reload[n] && !ch_update[n]));
      // R11
      halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_start[n] && !ch_update[n]) |=> $stable(live_cnt[n]));
      // R5
      step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_tick[n] && !ch_update[n] && live_cnt[n] != '0) |=>
          live_cnt[n] == CNT_W'($past(live_cnt[n]) - 1'b1));
      // R10
      stop_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_reload[n] && !ch_update[n] && live_cnt[n] == '0) |=> !expire[n] && live_cnt[n] == '0);
    end
  endgenerate

  // R12
  no_ch4_pin_chk: assert property (@(posedge clk) disable iff (!rst_n) !pin_all[NCH-1]);
endmodule

bind pwm_timer_top pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_start(ch_start), .ch_update(ch_update),
  .ch_reload(ch_reload), .ch_tick(ch_tick), .live_cnt(live_cnt), .cnt_buf(cnt_buf),
  .expire(expire), .pin_all(pin_all)
);

// File: tb/tb_pwm_timer_top.sv
module tb_pwm_timer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_pin;
  logic [4:0]  expire;

  int checks = 0;
  int fails = 0;
  logic [31:0] ctl_sh = '0;
  logic [31:0] psc_sh = '0;
  logic [31:0] div_sh = '0;

  always #2 clk = ~clk;

  pwm_timer_top dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_pin(pwm_pin), .expire(expire)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    summary();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  function automatic int pos(input int n);
    return (n < 4) ? 4 * n : 16;
  endfunction

  task automatic set_ctl(input int n, input bit st, input bit up, input bit inv, input bit rl);
    ctl_sh[pos(n)] = st;
    ctl_sh[pos(n) + 1] = up;
    if (n < 4) begin
      ctl_sh[pos(n) + 2] = inv;
      ctl_sh[pos(n) + 3] = rl;
    end else begin
      ctl_sh[pos(n) + 2] = rl;
    end
    wr(2, ctl_sh);
  endtask

  task automatic set_psc(input int n, input int p);
    if (n < 2) psc_sh[7:0] = 8'(p); else psc_sh[15:8] = 8'(p);
    wr(0, psc_sh);
  endtask

  task automatic set_sel(input int n, input int s);
    div_sh[4*n +: 4] = 4'(s);
    wr(1, div_sh);
  endtask

  task automatic launch(input int n, input int cnt, input int cmp, input bit inv);
    set_ctl(n, 1'b0, 1'b0, inv, 1'b1);
    wr(3 + 3 * n, 32'(cnt));
    if (n < 4) wr(4 + 3 * n, 32'(cmp));
    set_ctl(n, 1'b0, 1'b1, inv, 1'b1);
    set_ctl(n, 1'b1, 1'b0, inv, 1'b1);
  endtask

  // measures one expiry-to-expiry interval and the pin-high cycles inside it
  task automatic measure(input int n, input int p_exp, input int hi_exp, input string rp, input string rh);
    int t = 0;
    int p = 0;
    int hi = 0;
    @(negedge clk);
    while (!expire[n] && t < 5000) begin @(negedge clk); t++; end
    do begin
      if (n < 4 && pwm_pin[n]) hi++;
      p++;
      @(negedge clk);
    end while (!expire[n] && p < 5000);
    check(p == p_exp, rp, p, p_exp);
    if (n < 4) check(hi == hi_exp, rh, hi, hi_exp);
  endtask

  initial begin
    logic [31:0] d;
    int hi_cnt;
    int ex_cnt;
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 17; a++) begin
      rd(a, d);
      check(d == 0, "R1 reset read", int'(d), 0);
    end
    check(pwm_pin == 4'b0 && expire == 5'b0, "R1 reset outputs", int'({pwm_pin, expire}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_pin == 4'b0 && expire == 5'b0, "R1 after release", int'({pwm_pin, expire}), 0);

    // R2: register readback and ignored compare of channel 4
    wr(0, 32'h1234_5678); rd(0, d); check(d == 32'h1234_5678, "R2 prescaler word", int'(d), 32'h1234_5678);
    wr(1, 32'hCAFE_0123); rd(1, d); check(d == 32'hCAFE_0123, "R2 divider word", int'(d), 32'hCAFE_0123);
    wr(2, 32'h0004_0000); rd(2, d); check(d == 32'h0004_0000, "R2 control word", int'(d), 32'h0004_0000);
    wr(9, 32'h0000_1357); rd(9, d); check(d == 32'h1357, "R2 count buffer ch2", int'(d), 32'h1357);
    wr(13, 32'h0000_0246); rd(13, d); check(d == 32'h0246, "R2 compare buffer ch3", int'(d), 32'h0246);
    wr(16, 32'h0000_0009); rd(16, d); check(d == 0, "R2 ch4 compare ignored", int'(d), 0);
    rd(5, d); check(d == 0, "R2 unmapped word", int'(d), 0);
    wr(0, 0); wr(1, 0); wr(2, 0);

    // R3 R4 R5 R6 R7: sweep prescaler, divider, compare and invert on ch0 and ch2
    for (int ci = 0; ci < 2; ci++) begin
      automatic int n = (ci == 0) ? 0 : 2;
      for (int p = 0; p < 3; p++) begin
        for (int s = 0; s < 3; s++) begin
          for (int c = 0; c <= 4; c++) begin
            automatic int sp = (p + 1) * (1 << s);
            automatic bit inv = c[0];
            automatic int act = (4 - c) * sp;
            set_psc(n, p);
            set_sel(n, s);
            launch(n, 4, c, inv);
            measure(n, 5 * sp, inv ? 5 * sp - act : act, "R3 R4 R5 period", "R6 R7 duty");
          end
        end
      end
      set_ctl(n, 1'b0, 1'b0, 1'b0, 1'b0);
    end

    // R8: update held while running: no expiry, frozen pin
    set_psc(1, 0); set_sel(1, 0);
    wr(6, 3); wr(7, 1);
    set_ctl(1, 1'b1, 1'b1, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    hi_cnt = 0; ex_cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm_pin[1]) hi_cnt++;
      if (expire[1]) ex_cnt++;
    end
    check(ex_cnt == 0, "R8 no expiry while updating", ex_cnt, 0);
    check(hi_cnt == 40, "R8 pin frozen while updating", hi_cnt, 40);
    set_ctl(1, 1'b1, 1'b0, 1'b0, 1'b1);
    measure(1, 4, 2, "R8 period after update", "R8 duty after update");

    // R9: count buffer change lands only at a reload
    wr(6, 6);
    measure(1, 7, 5, "R9 new period after reload", "R9 duty after reload");

    // R11 R7: halt holds pin at invert level, restart resumes
    set_ctl(1, 1'b0, 1'b0, 1'b1, 1'b1);
    hi_cnt = 0; ex_cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_pin[1]) hi_cnt++;
      if (expire[1]) ex_cnt++;
    end
    check(hi_cnt == 20, "R7 R11 stopped pin at invert level", hi_cnt, 20);
    check(ex_cnt == 0, "R11 no expiry while halted", ex_cnt, 0);
    set_ctl(1, 1'b1, 1'b0, 1'b1, 1'b1);
    measure(1, 7, 2, "R11 period after resume", "R11 R7 inverted duty after resume");
    set_ctl(1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R10: no auto-reload stops at zero
    set_psc(3, 0); set_sel(3, 0);
    wr(12, 3); wr(13, 0);
    set_ctl(3, 1'b0, 1'b1, 1'b0, 1'b0);
    set_ctl(3, 1'b1, 1'b0, 1'b0, 1'b0);
    ex_cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (expire[3]) ex_cnt++;
    end
    check(ex_cnt == 0, "R10 no expiry without reload", ex_cnt, 0);
    check(pwm_pin[3] == 1'b0, "R10 pin inactive at zero", int'(pwm_pin[3]), 0);
    set_ctl(3, 1'b0, 1'b0, 1'b0, 1'b0);

    // R12: channel 4 interval timer on the second prescaler
    set_psc(4, 1); set_sel(4, 1);
    launch(4, 5, 0, 1'b0);
    measure(4, 24, 0, "R12 ch4 period", "R12 ch4");
    check(pwm_pin == 4'b0, "R12 no pin activity from ch4", int'(pwm_pin), 0);

    summary();
  end
endmodule